// File: doc/BRIEF.md
# Test Access Port Controller with Bypass and Output Float

This block is a boundary-scan test access port driven by its own test clock. A sixteen-state controller walks the standard scan graph under the mode-select input. A three-bit instruction register chooses which data path sits between the serial input and the serial output. The path is either a one-stage bypass register inside the block or an external boundary chain reached through a port.

The opcode space is small. Two codes drive the external chain: one for driving pins from the chain and one for sampling or preloading it. One code floats every pad output of the chip and routes scan data through the bypass stage. Every other code is a bypass instruction. Leaving reset puts a bypass code in the instruction register, so the chip's pads keep driving normally.

The serial output and its enable change only on the falling test-clock edge. The enable is high only while a register is being shifted.

Top module: `tap_port`

## Requirements
- R1: The controller follows the sixteen-state scan graph on the rising test-clock edge. Five consecutive rising edges with mode-select high reach Test-Logic-Reset from any state.
- R2: In Test-Logic-Reset the active instruction becomes 3'b111, which is a bypass code. This happens on the falling edge. `pad_hiz`, `extest_en` and `chain_sel` are then all low.
- R3: In Capture-IR the instruction shift stage loads 3'b001. In Shift-IR it shifts toward bit 0, with TDI entering at bit 2. The bits seen on `tdo` during an instruction shift are therefore 1, 0, 0, and bit 0 of the new opcode is the first bit shifted in.
- R4: The active instruction and the outputs decoded from it change only on the falling edge while the controller is in Update-IR, or in Test-Logic-Reset. They keep their old values through Exit1-IR and up to that falling edge.
- R5: Opcode 3'b000 sets `chain_sel` and `extest_en`. Opcode 3'b001 sets `chain_sel` only. With the chain selected, `tdo` in Shift-DR carries `chain_so`, sampled on each falling edge.
- R6: Opcodes 3'b010, 3'b011, 3'b101, 3'b110 and 3'b111 select the bypass stage. `chain_sel`, `extest_en` and `pad_hiz` are low, and data comes out of `tdo` one clock after it enters on `tdi`.
- R7: Opcode 3'b100 raises `pad_hiz` and selects the bypass stage, with the same one-clock path as R6.
- R8: When the bypass stage is selected it loads 0 in Capture-DR, so the first bit out of every data shift is 0.
- R9: `tdo` and `tdo_oe` update on the falling test-clock edge. `tdo_oe` is high only after a falling edge in Shift-IR or Shift-DR.
- R10: `chain_capture`, `chain_shift` and `chain_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while the chain is selected.
- R11: A low `trst_n` at once puts the controller in Test-Logic-Reset and the active instruction back to 3'b111, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial scan input |
| tdo | output | 1 | Serial scan output, valid while tdo_oe is high |
| tdo_oe | output | 1 | Output enable for tdo |
| chain_tdi | output | 1 | Serial input forwarded to the external boundary chain |
| chain_so | input | 1 | Serial output returned from the external boundary chain |
| chain_sel | output | 1 | External chain is the selected data register |
| chain_capture | output | 1 | Chain capture strobe (Capture-DR) |
| chain_shift | output | 1 | Chain shift enable (Shift-DR) |
| chain_update | output | 1 | Chain update strobe (Update-DR) |
| extest_en | output | 1 | Pads driven from the boundary chain |
| pad_hiz | output | 1 | Float every pad output |

## Verification
All eight opcodes are loaded in a directed pass and then in random order. Each load is followed by a data shift of random length with random serial data and random chain data. A bypass path shows up as the input delayed by one clock with a leading 0, which sets it apart from the chain path, where `tdo` carries `chain_so`. The five bypass codes, the float code and the two chain codes each need their own decode result.

The decoded outputs are also sampled in Exit1-IR and just after the rising edge into Update-IR. This separates a correct falling-edge update from an early one.

Random mode-select walks followed by five ones, and a reset pulse in the middle of an operation, show that both ways back to Test-Logic-Reset clear the float state.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_EX2_DR = 4'h0,
      ST_EX1_DR = 4'h1,
      ST_SH_DR  = 4'h2,
      ST_PAU_DR = 4'h3,
      ST_SEL_IR = 4'h4,
      ST_UPD_DR = 4'h5,
      ST_CAP_DR = 4'h6,
      ST_SEL_DR = 4'h7,
      ST_EX2_IR = 4'h8,
      ST_EX1_IR = 4'h9,
      ST_SH_IR  = 4'hA,
      ST_PAU_IR = 4'hB,
      ST_IDLE   = 4'hC,
      ST_UPD_IR = 4'hD,
      ST_CAP_IR = 4'hE,
      ST_RESET  = 4'hF
   } tap_state_e;

   typedef enum logic [1:0] {
      INS_EXTEST = 2'd0,
      INS_SAMPLE = 2'd1,
      INS_BYPASS = 2'd2,
      INS_HIZ    = 2'd3
   } tap_ins_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e st,
   output logic       in_reset,
   output logic       cap_ir,
   output logic       sh_ir,
   output logic       upd_ir,
   output logic       cap_dr,
   output logic       sh_dr,
   output logic       upd_dr
);

   tap_state_e st_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RESET;
      else        st_q <= tap_next(st_q, tms);
   end

   always_comb begin
      st       = st_q;
      in_reset = (st_q == ST_RESET);
      cap_ir   = (st_q == ST_CAP_IR);
      sh_ir    = (st_q == ST_SH_IR);
      upd_ir   = (st_q == ST_UPD_IR);
      cap_dr   = (st_q == ST_CAP_DR);
      sh_dr    = (st_q == ST_SH_DR);
      upd_dr   = (st_q == ST_UPD_DR);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int              IR_W      = 3,
   parameter logic [IR_W-1:0] OP_EXTEST = '0,
   parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(1),
   parameter logic [IR_W-1:0] OP_HIZ    = IR_W'(4),
   parameter logic [IR_W-1:0] IR_RESET  = '1,
   parameter logic [IR_W-1:0] IR_CAPT   = IR_W'(1)
)(
   input  logic     tck,
   input  logic     rst_n,
   input  logic     tdi,
   input  logic     in_reset,
   input  logic     capture,
   input  logic     shift,
   input  logic     update,
   output logic     sr_out,
   output tap_ins_e ins
);

   localparam int MSB = IR_W - 1;

   if (IR_W < 2) begin : g_bad_width
      $error("tap_ir: IR_W must be at least 2");
   end
   if (OP_EXTEST == OP_SAMPLE || OP_EXTEST == OP_HIZ || OP_SAMPLE == OP_HIZ) begin : g_bad_ops
      $error("tap_ir: instruction opcodes must be distinct");
   end
   if (IR_RESET == OP_EXTEST || IR_RESET == OP_SAMPLE || IR_RESET == OP_HIZ) begin : g_bad_rst
      $error("tap_ir: reset opcode must decode to bypass");
   end

   logic [MSB:0] sr_q;
   logic [MSB:0] code_q;

   // capture / shift stage, rising edge
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       sr_q <= IR_RESET;
      else if (capture) sr_q <= IR_CAPT;
      else if (shift)   sr_q <= {tdi, sr_q[MSB:1]};
   end

   // active instruction, falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)        code_q <= IR_RESET;
      else if (in_reset) code_q <= IR_RESET;
      else if (update)   code_q <= sr_q;
   end

   always_comb begin
      if (code_q == OP_EXTEST)      ins = INS_EXTEST;
      else if (code_q == OP_SAMPLE) ins = INS_SAMPLE;
      else if (code_q == OP_HIZ)    ins = INS_HIZ;
      else                          ins = INS_BYPASS;
   end

   assign sr_out = sr_q[0];

endmodule

// File: rtl/tap_bypass.sv
module tap_bypass (
   input  logic tck,
   input  logic rst_n,
   input  logic sel,
   input  logic capture,
   input  logic shift,
   input  logic tdi,
   output logic q
);

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)                q <= 1'b0;
      else if (sel && capture)   q <= 1'b0;
      else if (sel && shift)     q <= tdi;
   end

endmodule

// File: rtl/tap_port.sv
module tap_port
   import tap_pkg::*;
#(
   parameter int              IR_W      = 3,
   parameter logic [IR_W-1:0] OP_EXTEST = '0,
   parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(1),
   parameter logic [IR_W-1:0] OP_HIZ    = IR_W'(4),
   parameter logic [IR_W-1:0] IR_RESET  = '1,
   parameter logic [IR_W-1:0] IR_CAPT   = IR_W'(1),
   parameter bit              HAS_TRST  = 1'b1
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_oe,
   output logic chain_tdi,
   input  logic chain_so,
   output logic chain_sel,
   output logic chain_capture,
   output logic chain_shift,
   output logic chain_update,
   output logic extest_en,
   output logic pad_hiz
);

   logic       rst_n;
   tap_state_e st;
   logic       in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
   logic       ir_so;
   tap_ins_e   ins;
   logic       byp_q;
   logic       tdo_q, oe_q;

   if (HAS_TRST) begin : g_trst
      assign rst_n = trst_n;
   end else begin : g_no_trst
      logic unused_trst;
      assign unused_trst = trst_n;
      assign rst_n       = 1'b1;
   end

   tap_fsm u_fsm (
      .tck      (tck),
      .rst_n    (rst_n),
      .tms      (tms),
      .st       (st),
      .in_reset (in_reset),
      .cap_ir   (cap_ir),
      .sh_ir    (sh_ir),
      .upd_ir   (upd_ir),
      .cap_dr   (cap_dr),
      .sh_dr    (sh_dr),
      .upd_dr   (upd_dr)
   );

   tap_ir #(
      .IR_W      (IR_W),
      .OP_EXTEST (OP_EXTEST),
      .OP_SAMPLE (OP_SAMPLE),
      .OP_HIZ    (OP_HIZ),
      .IR_RESET  (IR_RESET),
      .IR_CAPT   (IR_CAPT)
   ) u_ir (
      .tck      (tck),
      .rst_n    (rst_n),
      .tdi      (tdi),
      .in_reset (in_reset),
      .capture  (cap_ir),
      .shift    (sh_ir),
      .update   (upd_ir),
      .sr_out   (ir_so),
      .ins      (ins)
   );

   tap_bypass u_byp (
      .tck     (tck),
      .rst_n   (rst_n),
      .sel     (!chain_sel),
      .capture (cap_dr),
      .shift   (sh_dr),
      .tdi     (tdi),
      .q       (byp_q)
   );

   always_comb begin
      chain_sel     = (ins == INS_EXTEST) || (ins == INS_SAMPLE);
      extest_en     = (ins == INS_EXTEST);
      pad_hiz       = (ins == INS_HIZ);
      chain_capture = chain_sel && cap_dr;
      chain_shift   = chain_sel && sh_dr;
      chain_update  = chain_sel && upd_dr;
      chain_tdi     = tdi;
   end

   // serial output stage, falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q <= sh_ir || sh_dr;
         if (sh_ir)      tdo_q <= ir_so;
         else if (sh_dr) tdo_q <= chain_sel ? chain_so : byp_q;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
   import tap_pkg::*;
(
   input logic       tck,
   input logic       rst_n,
   input logic       tms,
   input logic       tdi,
   input tap_state_e st,
   input logic       byp_q,
   input logic       tdo,
   input logic       tdo_oe,
   input logic       chain_sel,
   input logic       extest_en,
   input logic       pad_hiz
);

   logic [2:0] ones_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)               ones_q <= 3'd0;
      else if (!tms)            ones_q <= 3'd0;
      else if (ones_q != 3'd5)  ones_q <= ones_q + 3'd1;
   end

   AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
      (ones_q == 3'd5) |-> (st == ST_RESET)); // R1

   AST_RESET_CLEARS_INS: assert property (@(posedge tck) disable iff (!rst_n)
      (st == ST_RESET) |=> (!pad_hiz && !chain_sel && !extest_en)); // R2

   AST_INS_CHANGE_WINDOW: assert property (@(posedge tck) disable iff (!rst_n)
      !$stable({pad_hiz, chain_sel, extest_en}) |-> (st == ST_UPD_IR || st == ST_RESET)); // R4

   AST_BYP_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
      (st == ST_SH_DR && !chain_sel) |=> (byp_q == $past(tdi))); // R6

   AST_BYP_TO_TDO: assert property (@(negedge tck) disable iff (!rst_n)
      (st == ST_SH_DR && !chain_sel) |=> (tdo == $past(byp_q))); // R7

   AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
      (st == ST_CAP_DR && !chain_sel) |=> (byp_q == 1'b0)); // R8

   AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
      tdo_oe |-> (st == ST_SH_IR || st == ST_SH_DR)); // R9

endmodule

bind tap_port tap_port_chk u_chk (
   .tck       (tck),
   .rst_n     (rst_n),
   .tms       (tms),
   .tdi       (tdi),
   .st        (st),
   .byp_q     (byp_q),
   .tdo       (tdo),
   .tdo_oe    (tdo_oe),
   .chain_sel (chain_sel),
   .extest_en (extest_en),
   .pad_hiz   (pad_hiz)
);

// File: tb/tap_port_tb.sv
`timescale 1ns/1ps
module tap_port_tb;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic chain_so = 1'b0;
   logic tdo, tdo_oe, chain_tdi, chain_sel, chain_capture, chain_shift, chain_update;
   logic extest_en, pad_hiz;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 tck = ~tck;

   tap_port u_dut (
      .tck           (tck),
      .trst_n        (trst_n),
      .tms           (tms),
      .tdi           (tdi),
      .tdo           (tdo),
      .tdo_oe        (tdo_oe),
      .chain_tdi     (chain_tdi),
      .chain_so      (chain_so),
      .chain_sel     (chain_sel),
      .chain_capture (chain_capture),
      .chain_shift   (chain_shift),
      .chain_update  (chain_update),
      .extest_en     (extest_en),
      .pad_hiz       (pad_hiz)
   );

   // expected decode: 0 extest, 1 sample, 2 bypass, 3 float
   function automatic int exp_kind(input logic [2:0] op);
      case (op)
         3'b000:  return 0;
         3'b001:  return 1;
         3'b100:  return 3;
         default: return 2;
      endcase
   endfunction

   function automatic logic [2:0] exp_outs(input int k);
      // {chain_sel, extest_en, pad_hiz}
      return {k < 2, k == 0, k == 3};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_dec(input string req, input int k);
      logic [2:0] got;
      got = {chain_sel, extest_en, pad_hiz};
      chk(got == exp_outs(k), req, got, exp_outs(k));
   endtask

   // drive at falling edge, read tdo there, return just after rising edge
   task automatic tick(input logic m, input logic d, input logic c, output logic o);
      @(negedge tck);
      #1;
      o        = tdo;
      tms      = m;
      tdi      = d;
      chain_so = c;
      @(posedge tck);
      #1;
   endtask

   task automatic step(input logic m);
      logic o;
      tick(m, 1'b0, 1'b0, o);
   endtask

   // from Run-Test/Idle, load an opcode and return to Run-Test/Idle
   task automatic load_ir(input logic [2:0] op, input int old_k);
      logic o;
      step(1'b1);
      step(1'b1);
      step(1'b0);
      step(1'b0);
      for (int i = 0; i < 3; i++) begin
         tick(i == 2, op[i], 1'b0, o);
         chk(o == (i == 0), "R3 captured instruction bit", o, i == 0);
         if (i == 0) chk(tdo_oe == 1'b1, "R9 oe in Shift-IR", tdo_oe, 1);
      end
      chk_dec("R4 held in Exit1-IR", old_k);
      step(1'b1);
      chk_dec("R4 held until falling edge in Update-IR", old_k);
      step(1'b0);
      chk_dec("R5 R6 R7 decode after update", exp_kind(op));
      chk(tdo_oe == 1'b0, "R9 oe low outside shift", tdo_oe, 0);
   endtask

   task automatic shift_dr(input int n, input int k);
      logic o;
      logic prev;
      logic d, c;
      bit   on_chain;
      on_chain = (k < 2);
      step(1'b1);
      step(1'b0);
      chk(chain_capture == on_chain, "R10 capture strobe", chain_capture, on_chain);
      prev = 1'($urandom);
      tick(1'b0, 1'b0, prev, o);
      chk(chain_shift == on_chain, "R10 shift enable", chain_shift, on_chain);
      if (!on_chain) prev = 1'b0;
      for (int i = 0; i < n; i++) begin
         d = 1'($urandom);
         c = 1'($urandom);
         tick(i == n - 1, d, c, o);
         if (on_chain)
            chk(o == prev, "R5 chain data on tdo", o, prev);
         else if (i == 0)
            chk(o == 1'b0, "R8 first bypass bit is zero", o, 0);
         else
            chk(o == prev, (k == 3) ? "R7 float routes through bypass" : "R6 bypass delay", o, prev);
         prev = on_chain ? c : d;
      end
      step(1'b1);
      chk(chain_update == on_chain, "R10 update strobe", chain_update, on_chain);
      step(1'b0);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      int cur_k;
      logic [2:0] op;
      void'($urandom(32'h5ca1ab1e));
      #23;
      chk(tdo_oe == 1'b0, "R11 oe low in reset", tdo_oe, 0);
      chk_dec("R2 reset decode is bypass", 2);
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      tms    = 1'b0;
      @(posedge tck);
      #1;
      cur_k = 2;

      // directed: every opcode once
      for (int j = 0; j < 8; j++) begin
         op = 3'(j);
         load_ir(op, cur_k);
         cur_k = exp_kind(op);
         shift_dr(4, cur_k);
      end

      // random opcodes and shift lengths
      for (int j = 0; j < 40; j++) begin
         op = 3'($urandom);
         load_ir(op, cur_k);
         cur_k = exp_kind(op);
         shift_dr(2 + int'($urandom % 9), cur_k);
      end

      // random walk, then five ones
      for (int j = 0; j < 6; j++) begin
         load_ir(3'b100, cur_k);
         cur_k = 3;
         for (int s = 0; s < 15; s++) step(1'($urandom));
         for (int s = 0; s < 5; s++) step(1'b1);
         @(negedge tck);
         #1;
         chk(pad_hiz == 1'b0, "R1 R2 five ones clear float", pad_hiz, 0);
         chk(tdo_oe == 1'b0, "R1 oe low in reset", tdo_oe, 0);
         step(1'b0);
         cur_k = 2;
      end

      // asynchronous reset in the middle of a data shift
      load_ir(3'b100, cur_k);
      chk_dec("R7 float set before reset", 3);
      step(1'b1);
      step(1'b0);
      step(1'b0);
      #2;
      trst_n = 1'b0;
      #1;
      chk(pad_hiz == 1'b0, "R11 async reset clears float", pad_hiz, 0);
      chk(tdo_oe == 1'b0, "R11 async reset drops oe", tdo_oe, 0);
      @(negedge tck);
      #1;
      trst_n = 1'b1;
      tms    = 1'b0;
      @(posedge tck);
      #1;
      load_ir(3'b011, 2);
      shift_dr(5, 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule